// File: doc/BRIEF.md
# Host Controller Dual-Reset-Domain Register Block

This block holds the software-visible control and status registers of a USB host controller. A plain 32-bit register bus reaches it, addressed in 32-bit word units, with a word address, write enable, byte strobes and write data. Read data returns combinationally for the current address. The map begins with a read-only capability section. The capability section reports its own length in words, and the operational section starts at that word offset.

Each bit has its own access type: read/write, read-only, write-only, or write-one-to-clear. Hardware event inputs set the status bits and software clears them. Most registers sit in the core reset domain, and one configuration register sits in the auxiliary domain. Each domain has its own asynchronous active-low reset, which is released synchronously. A software reset bit in the control register returns both domains to their defaults and then clears itself. A one-cycle wake pulse, which signals a return from the deep sleep power state, resets the core domain only.

Top module: `hc_regfile`

## Requirements
- R1: Word 0 reads {16'h0100, 8'h00, capability length in words (default 4)}. Word 1 reads the number of event status bits (default 4) in bits [7:0]. The other capability words read zero. Writes to any capability word have no effect.
- R2: Operational registers sit at capability length + 0 (control), +1 (status), +2 (doorbell) and +3 (auxiliary configuration). Any other offset reads zero, and a write to it changes no register.
- R3: Read/write fields are updated only in the bytes whose strobe is set. The fields are control bit 0 (run), control bits [11:8] (threshold, default 8) and auxiliary bits [7:0] (default 8'h3C). Reserved bits read zero.
- R4: Status bit 12 reads as the inverse of the run bit, and writes to it have no effect.
- R5: Status bits [3:0] are write-one-to-clear. Writing 1 clears a bit, and writing 0 leaves it unchanged.
- R6: A high event input sets its status bit on the next clock edge. If the same cycle also carries a clear for that bit, the bit still ends up set.
- R7: The doorbell register is write-only. It reads zero, and its byte-strobed value appears on the doorbell output (default 0).
- R8: Writing 1 to control bit 1 makes the bit read 1 for exactly one cycle. On the following edge, both domains return to their defaults and the bit reads 0.
- R9: Asserting the core hardware reset returns control, status and doorbell to their defaults and leaves the auxiliary register unchanged.
- R10: Asserting the auxiliary reset returns the auxiliary register to its default and leaves the core registers unchanged.
- R11: A one-cycle wake pulse resets the core domain on the next edge and leaves the auxiliary register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aux_rst_n | input | 1 | Auxiliary domain reset, asynchronous, active low |
| core_rst_n | input | 1 | Core domain reset, asynchronous, active low |
| d0_wake | input | 1 | One-cycle pulse on return from deep sleep |
| reg_addr | input | 6 | Word address |
| reg_we | input | 1 | Write enable |
| reg_be | input | 4 | Byte strobes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| evt_set | input | 4 | Hardware event inputs for the status bits |
| ctrl_run | output | 1 | Run bit |
| ctrl_thresh | output | 4 | Threshold field |
| doorbell | output | 32 | Doorbell register value |
| aux_cfg | output | 8 | Auxiliary configuration value |

## Verification
The bench targets a software reset that takes effect in the same cycle it is written. Such a design would never show the bit as 1, and the bench catches this because it reads control exactly one cycle after the write. A clear that beats a coincident event would lose a status bit. Resets that leak across domains would wipe the auxiliary value on a core or wake reset. The bench also writes to unmapped and capability offsets, and to a read-only bit. A decode that aliases these writes would corrupt control or report a halted state that does not match the run bit.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_DOOR = 2;
  localparam int OFS_AUX  = 3;
  localparam int OP_WORDS = 4;

  localparam int B_RUN   = 0;
  localparam int B_HCRST = 1;
  localparam int B_THR   = 8;
  localparam int THR_W   = 4;
  localparam int B_HALT  = 12;
  localparam int AUX_W   = 8;

  localparam logic [15:0]      IF_VERSION = 16'h0100;
  localparam logic [THR_W-1:0] THR_DEF    = 4'h8;
  localparam logic [AUX_W-1:0] AUX_DEF    = 8'h3C;

  typedef enum logic [2:0] {
    RS_NONE, RS_CAP0, RS_CAP1, RS_CTRL, RS_STAT, RS_AUX
  } rsel_e;

  function automatic logic [31:0] be_to_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/hc_rst_sync.sv
module hc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hc_bus_decode.sv
module hc_bus_decode
  import hc_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CAP_DW = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output rsel_e             rsel,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_door,
  output logic              wr_aux
);
  localparam logic [ADDR_W-1:0] CAP_END = ADDR_W'(CAP_DW);

  logic              in_cap;
  logic [ADDR_W-1:0] op_idx;

  always_comb begin
    in_cap  = (addr < CAP_END);
    op_idx  = addr - CAP_END;
    rsel    = RS_NONE;
    wr_ctrl = 1'b0;
    wr_stat = 1'b0;
    wr_door = 1'b0;
    wr_aux  = 1'b0;
    if (in_cap) begin
      if (addr == ADDR_W'(0))      rsel = RS_CAP0;
      else if (addr == ADDR_W'(1)) rsel = RS_CAP1;
    end else begin
      case (op_idx)
        ADDR_W'(OFS_CTRL): begin rsel = RS_CTRL; wr_ctrl = we; end
        ADDR_W'(OFS_STAT): begin rsel = RS_STAT; wr_stat = we; end
        ADDR_W'(OFS_DOOR): begin wr_door = we; end
        ADDR_W'(OFS_AUX):  begin rsel = RS_AUX;  wr_aux  = we; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hc_core_well.sv
module hc_core_well
  import hc_regs_pkg::*;
#(
  parameter int NEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wake,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic             wr_door,
  input  logic [31:0]      wmask,
  input  logic [31:0]      wdata,
  input  logic [NEV-1:0]   evt_set,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      stat_rd,
  output logic             run,
  output logic [THR_W-1:0] thresh,
  output logic [31:0]      door,
  output logic             hcrst
);
  logic             sclr;
  logic             run_q, run_d;
  logic             hcrst_q, hcrst_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [31:0]      door_q, door_d;
  logic [NEV-1:0]   stat_q, stat_d, clr_vec;
  logic             ctrl_en, door_en, stat_en;

  assign sclr = wake | hcrst_q;

  // control register next state
  always_comb begin
    ctrl_en = sclr | wr_ctrl;
    run_d   = run_q;
    hcrst_d = hcrst_q;
    thr_d   = thr_q;
    if (sclr) begin
      run_d   = 1'b0;
      hcrst_d = 1'b0;
      thr_d   = THR_DEF;
    end else if (wr_ctrl) begin
      if (wmask[B_RUN]) run_d = wdata[B_RUN];
      if (wmask[B_HCRST] && wdata[B_HCRST]) hcrst_d = 1'b1;
      for (int i = 0; i < THR_W; i++)
        if (wmask[B_THR+i]) thr_d[i] = wdata[B_THR+i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hcrst_q <= 1'b0;
      thr_q   <= THR_DEF;
    end else if (ctrl_en) begin
      run_q   <= run_d;
      hcrst_q <= hcrst_d;
      thr_q   <= thr_d;
    end
  end

  // doorbell register next state
  always_comb begin
    door_en = sclr | wr_door;
    if (sclr) door_d = '0;
    else      door_d = (door_q & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       door_q <= '0;
    else if (door_en) door_q <= door_d;
  end

  // status bits: set by events, cleared by writing one
  assign clr_vec = wdata[NEV-1:0] & wmask[NEV-1:0] & {NEV{wr_stat}};

  for (genvar gi = 0; gi < NEV; gi++) begin : g_evt
    always_comb begin
      if (sclr) stat_d[gi] = 1'b0;
      else      stat_d[gi] = evt_set[gi] | (stat_q[gi] & ~clr_vec[gi]);
    end
  end

  assign stat_en = sclr | wr_stat | (|evt_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_RUN]   = run_q;
    ctrl_rd[B_HCRST] = hcrst_q;
    ctrl_rd[B_THR +: THR_W] = thr_q;
    stat_rd = '0;
    stat_rd[NEV-1:0] = stat_q;
    stat_rd[B_HALT]  = ~run_q;
  end

  assign run    = run_q;
  assign thresh = thr_q;
  assign door   = door_q;
  assign hcrst  = hcrst_q;

  AST_HCRST_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    hcrst_q |=> !hcrst_q) else $error("software reset bit stuck"); // R8

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_set) && !sclr) |=> ((stat_q & $past(evt_set)) == $past(evt_set)))
    else $error("event lost"); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !sclr && evt_set == '0) |=> ((stat_q & $past(clr_vec)) == '0))
    else $error("status bit not cleared"); // R5

  AST_WAKE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!run_q && thr_q == THR_DEF && stat_q == '0 && door_q == '0))
    else $error("wake did not reset core"); // R11
endmodule

// File: rtl/hc_aux_well.sv
module hc_aux_well
  import hc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclr,
  input  logic             wr_aux,
  input  logic [AUX_W-1:0] wmask,
  input  logic [AUX_W-1:0] wdata,
  output logic [AUX_W-1:0] cfg
);
  logic [AUX_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = sclr | wr_aux;
    if (sclr) cfg_d = AUX_DEF;
    else      cfg_d = (cfg_q & ~wmask) | (wdata & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= AUX_DEF;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclr && !wr_aux) |=> $stable(cfg_q)) else $error("aux value disturbed"); // R9
endmodule

// File: rtl/hc_regfile.sv
module hc_regfile
  import hc_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CAP_DW = 4,
  parameter int NEV    = 4
) (
  input  logic              clk,
  input  logic              aux_rst_n,
  input  logic              core_rst_n,
  input  logic              d0_wake,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NEV-1:0]    evt_set,
  output logic              ctrl_run,
  output logic [THR_W-1:0]  ctrl_thresh,
  output logic [31:0]       doorbell,
  output logic [AUX_W-1:0]  aux_cfg
);
  logic        core_srst_n, aux_srst_n;
  rsel_e       rsel;
  logic        wr_ctrl, wr_stat, wr_door, wr_aux;
  logic [31:0] wmask;
  logic [31:0] ctrl_rd, stat_rd;
  logic        hcrst;

  assign wmask = be_to_mask(reg_be);

  hc_rst_sync #(.STAGES(2)) u_core_sync (
    .clk(clk), .arst_n(core_rst_n), .srst_n(core_srst_n));
  hc_rst_sync #(.STAGES(2)) u_aux_sync (
    .clk(clk), .arst_n(aux_rst_n), .srst_n(aux_srst_n));

  hc_bus_decode #(.ADDR_W(ADDR_W), .CAP_DW(CAP_DW)) u_dec (
    .addr(reg_addr), .we(reg_we), .rsel(rsel),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_door(wr_door), .wr_aux(wr_aux));

  hc_core_well #(.NEV(NEV)) u_core (
    .clk(clk), .rst_n(core_srst_n), .wake(d0_wake),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_door(wr_door),
    .wmask(wmask), .wdata(reg_wdata), .evt_set(evt_set),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .run(ctrl_run),
    .thresh(ctrl_thresh), .door(doorbell), .hcrst(hcrst));

  hc_aux_well u_aux (
    .clk(clk), .rst_n(aux_srst_n), .sclr(hcrst), .wr_aux(wr_aux),
    .wmask(wmask[AUX_W-1:0]), .wdata(reg_wdata[AUX_W-1:0]), .cfg(aux_cfg));

  always_comb begin
    reg_rdata = '0;
    case (rsel)
      RS_CAP0: reg_rdata = {IF_VERSION, 8'h00, 8'(CAP_DW)};
      RS_CAP1: reg_rdata = {24'h0, 8'(NEV)};
      RS_CTRL: reg_rdata = ctrl_rd;
      RS_STAT: reg_rdata = stat_rd;
      RS_AUX:  reg_rdata = {{(32-AUX_W){1'b0}}, aux_cfg};
      default: reg_rdata = '0;
    endcase
  end

  AST_HALT_TRACKS_RUN: assert property (@(posedge clk) disable iff (!core_srst_n)
    (rsel == RS_STAT) |-> (reg_rdata[B_HALT] == !ctrl_run))
    else $error("halt bit mismatch"); // R4
endmodule

// File: tb/test_hc_regfile.sv
module test_hc_regfile;
  localparam int PER = 10;
  localparam int CTRL = 4, STAT = 5, DOOR = 6, AUXR = 7;

  logic        clk = 1'b0;
  logic        aux_rst_n, core_rst_n, d0_wake, reg_we;
  logic [5:0]  reg_addr;
  logic [3:0]  reg_be, evt_set;
  logic [31:0] reg_wdata, reg_rdata, doorbell;
  logic        ctrl_run;
  logic [3:0]  ctrl_thresh;
  logic [7:0]  aux_cfg;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #(PER/2) clk = ~clk;

  hc_regfile i_hc_regfile (
    .clk(clk), .aux_rst_n(aux_rst_n), .core_rst_n(core_rst_n), .d0_wake(d0_wake),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_set(evt_set), .ctrl_run(ctrl_run),
    .ctrl_thresh(ctrl_thresh), .doorbell(doorbell), .aux_cfg(aux_cfg));

  // monitor: pops expected items and compares with observed values
  initial begin
    forever begin
      @(negedge clk);
      #(PER/4);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] obs;
        it = exp_q.pop_front();
        case (it.sel)
          0: obs = reg_rdata;
          1: obs = {31'h0, ctrl_run};
          2: obs = doorbell;
          3: obs = {24'h0, aux_cfg};
          default: obs = {28'h0, ctrl_thresh};
        endcase
        total++;
        if (obs !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%08h expected=%08h", it.tag, obs, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input logic wk = 1'b0, input logic [3:0] ev = 4'h0);
    @(negedge clk);
    reg_we = 1'b0; d0_wake = wk; evt_set = ev;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d,
                    input logic [3:0] ev = 4'h0);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_we = 1'b1;
    evt_set = ev; d0_wake = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_we = 1'b0; d0_wake = 1'b0; evt_set = 4'h0; reg_addr = a;
    expect_v(0, e, tag);
  endtask

  initial begin
    #(PER*50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    aux_rst_n = 0; core_rst_n = 0; d0_wake = 0; reg_we = 0;
    reg_addr = '0; reg_be = '0; reg_wdata = '0; evt_set = '0;
    repeat (3) @(negedge clk);
    aux_rst_n = 1; core_rst_n = 1;
    repeat (4) idle();

    // reset state and capability section
    rd(0, 32'h0100_0004, "R1 cap word0");
    rd(1, 32'h0000_0004, "R1 cap word1");
    rd(2, 32'h0, "R1 cap word2");
    rd(CTRL, 32'h0000_0800, "R9 reset ctrl");
    rd(STAT, 32'h0000_1000, "R9 reset stat");
    rd(AUXR, 32'h0000_003C, "R10 reset aux");
    expect_v(1, 0, "R9 reset run");
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd(0, 32'h0100_0004, "R1 cap write ignored");

    // byte strobes and reserved bits
    wr(CTRL, 4'b0010, 32'hFFFF_FFFF);
    rd(CTRL, 32'h0000_0F00, "R3 byte1 only");
    expect_v(4, 32'hF, "R3 thresh port");
    wr(CTRL, 4'b0001, 32'h0000_0001);
    rd(CTRL, 32'h0000_0F01, "R3 run set");
    expect_v(1, 1, "R3 run port");
    rd(STAT, 32'h0, "R4 halt follows run");
    wr(STAT, 4'hF, 32'h0000_1000);
    rd(STAT, 32'h0, "R4 halt write ignored");

    // status events and write-one-to-clear
    idle(1'b0, 4'b1010);
    rd(STAT, 32'h0000_000A, "R6 events set");
    wr(STAT, 4'hF, 32'h0000_0002);
    rd(STAT, 32'h0000_0008, "R5 clear bit1");
    wr(STAT, 4'hF, 32'h0);
    rd(STAT, 32'h0000_0008, "R5 zero write keeps");
    wr(STAT, 4'hF, 32'h0000_000F, 4'b0001);
    rd(STAT, 32'h0000_0001, "R6 set wins over clear");

    // write-only doorbell
    wr(DOOR, 4'b0011, 32'hAABB_CCDD);
    rd(DOOR, 32'h0, "R7 doorbell reads zero");
    expect_v(2, 32'h0000_CCDD, "R7 doorbell port");

    // aux register with reserved bits
    wr(AUXR, 4'hF, 32'hFFFF_FF5A);
    rd(AUXR, 32'h0000_005A, "R3 aux reserved zero");

    // unmapped offsets
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd(8, 32'h0, "R2 unmapped reads zero");
    rd(CTRL, 32'h0000_0F01, "R2 unmapped write no effect");
    rd(63, 32'h0, "R2 top offset zero");
    rd(AUXR, 32'h0000_005A, "R2 aux untouched");

    // wake pulse resets core only
    idle(1'b1);
    rd(CTRL, 32'h0000_0800, "R11 ctrl default");
    expect_v(2, 32'h0, "R11 doorbell default");
    rd(STAT, 32'h0000_1000, "R11 stat default");
    rd(AUXR, 32'h0000_005A, "R11 aux kept");

    // core hardware reset
    wr(CTRL, 4'b0001, 32'h1);
    idle(1'b0, 4'b0100);
    @(negedge clk); core_rst_n = 0;
    repeat (2) idle();
    core_rst_n = 1;
    repeat (3) idle();
    rd(CTRL, 32'h0000_0800, "R9 ctrl after core reset");
    rd(STAT, 32'h0000_1000, "R9 stat after core reset");
    rd(AUXR, 32'h0000_005A, "R9 aux kept");

    // auxiliary reset
    wr(CTRL, 4'b0001, 32'h1);
    @(negedge clk); aux_rst_n = 0;
    repeat (2) idle();
    aux_rst_n = 1;
    repeat (3) idle();
    rd(AUXR, 32'h0000_003C, "R10 aux default");
    rd(CTRL, 32'h0000_0801, "R10 core kept");

    // software reset of both domains
    wr(AUXR, 4'hF, 32'h77);
    idle(1'b0, 4'b0010);
    wr(CTRL, 4'b0001, 32'h3);
    rd(CTRL, 32'h0000_0803, "R8 reset bit reads one");
    rd(CTRL, 32'h0000_0800, "R8 self cleared");
    rd(AUXR, 32'h0000_003C, "R8 aux default");
    rd(STAT, 32'h0000_1000, "R8 stat default");

    repeat (2) idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule